// File: doc/BRIEF.md
# Dot Clock Divider Search Engine

This block works out the divider settings for a pixel clock synthesizer that runs from a fixed 14,318,180 Hz reference. The caller pulses `start` with a requested frequency in Hz.

The engine first rejects requests outside 3.125 MHz to 220 MHz. For an accepted request it doubles the target until it lies at or above 100 MHz, and it records each doubling in the divisor byte. It then walks every reference divider N from 3 to 257, one per clock. For each N it takes the feedback divider M as the floor of N times the target divided by the reference, and it keeps the candidate with the smallest frequency error.

At the end it presents register-ready M, N and divisor bytes together with a one-cycle `done` pulse. M is not found by a divider. It advances by a precomputed quotient and remainder from one N to the next, so the only division is a short repeated subtraction done once per job.

Top module: `dclk_pll_search`

## Requirements
- R1: A start seen while idle with a target above 220,000,000 or below 3,125,000 makes `done` and `err` high on the next cycle, `busy` stays low, and the code outputs keep their previous values.
- R2: Targets of exactly 3,125,000 and exactly 220,000,000 are accepted: the job searches, and it finishes with `err` low.
- R3: Bits 7:4 of `div_code` give the number of doublings needed to bring the target to at least 100,000,000 Hz. That number is 0 when the target already reaches 100 MHz.
- R4: Every N from 3 to 257 is tried, with M = floor(N·F/14318180), where F is the doubled target. When 3 ≤ M ≤ 257 the score is N·F − 14318180·M. The chosen pair has the lowest score.
- R5: When 257 < M ≤ 1028, the score uses M with its two low bits cleared. Candidates with M above 1028 are never chosen.
- R6: A candidate replaces the current best only with a strictly lower score, so among equal scores the lowest N wins.
- R7: If the chosen M exceeds 257, `m_code` = (M>>2)−2 and `div_code` bit 2 is 0. Otherwise `m_code` = M−2 and bit 2 is 1. `n_code` = N−2. Bits 3, 1 and 0 of `div_code` are always 0.
- R8: `done` is high for exactly one cycle per job. `err`, `m_code`, `n_code` and `div_code` hold their values until the next accepted start.
- R9: A start pulse while `busy` is high is ignored, and the running job finishes with its own results.
- R10: After reset, `busy`, `done`, `err` and all code outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, taken only when idle |
| target_hz | input | 32 | Requested pixel clock in Hz |
| busy | output | 1 | A search is in progress |
| done | output | 1 | One-cycle job completion pulse |
| err | output | 1 | Last job was rejected as out of range |
| m_code | output | 8 | Feedback divider code |
| n_code | output | 8 | Reference divider code |
| div_code | output | 8 | Post-divider and loop-divide field |

## Verification
The search is driven with common display rates, with targets just below and at the 100 MHz band edge, with both acceptance limits, and with a sweep across the whole range. Each result is compared against a brute-force 64-bit model. The sweep spreads the doubling count and reaches targets where a four-times extended M wins, which separates the two scoring rules. An exact multiple of the reference gives zero error for many N, and so it shows whether ties keep the lowest N. Rejected targets on both sides of the range, and a start issued mid-search, show that neither path disturbs the held results.

// File: rtl/dclk_pll_search.sv
module dclk_pll_search #(
  parameter int unsigned REF_HZ    = 14318180,
  parameter int unsigned MIN_HZ    = 3125000,
  parameter int unsigned MAX_HZ    = 220000000,
  parameter int unsigned VCO_LO_HZ = 100000000,
  parameter int unsigned N_LO      = 3,
  parameter int unsigned N_HI      = 257,
  parameter int unsigned M_LO      = 3,
  parameter int unsigned M_HI      = 257,
  parameter int unsigned M_EXT_HI  = 1028,
  parameter int unsigned DIV_STEP  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] target_hz,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [7:0]  m_code,
  output logic [7:0]  n_code,
  output logic [7:0]  div_code
);

  localparam int unsigned QMAX = (2 * VCO_LO_HZ > MAX_HZ ? 2 * VCO_LO_HZ : MAX_HZ) / REF_HZ + 1;
  localparam int MW = $clog2(N_HI * QMAX + 1);
  localparam int NW = $clog2(N_HI + 1);
  localparam logic [MW-1:0] M_LO_W  = MW'(M_LO);
  localparam logic [MW-1:0] M_HI_W  = MW'(M_HI);
  localparam logic [MW-1:0] M_EXT_W = MW'(M_EXT_HI);
  localparam logic [NW-1:0] N_LO_W  = NW'(N_LO);
  localparam logic [NW-1:0] N_HI_W  = NW'(N_HI);
  localparam logic [7:0]    EXT_MIN_CODE = 8'(((M_HI + 1) >> 2) - 2);

  typedef enum logic [2:0] {S_IDLE, S_NORM, S_QUOT, S_SRCH, S_FIN} st_t;

  st_t            st;
  logic [31:0]    f_q, rem_q, r_q, best_e;
  logic [7:0]     div_q;
  logic [MW-1:0]  quo_q, m_q, best_m;
  logic [NW-1:0]  n_q, best_n;

  logic           out_of_range, m_in, m_ext, take, wrap;
  logic [31:0]    cand_e, r_sum;
  logic [MW-1:0]  sel_m;

  assign busy = (st != S_IDLE);
  assign out_of_range = (target_hz > MAX_HZ) || (target_hz < MIN_HZ);

  assign m_in   = (m_q >= M_LO_W) && (m_q <= M_HI_W);
  assign m_ext  = (m_q > M_HI_W) && (m_q <= M_EXT_W);
  assign cand_e = m_in ? r_q : r_q + REF_HZ * {30'd0, m_q[1:0]};
  assign take   = (n_q >= N_LO_W) && (m_in || m_ext) && (cand_e < best_e);

  assign r_sum  = r_q + rem_q;
  assign wrap   = (r_sum >= REF_HZ);
  assign sel_m  = (best_m > M_HI_W) ? (best_m >> 2) : best_m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      f_q      <= '0;
      rem_q    <= '0;
      r_q      <= '0;
      best_e   <= '1;
      div_q    <= '0;
      quo_q    <= '0;
      m_q      <= '0;
      best_m   <= '0;
      n_q      <= '0;
      best_n   <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      m_code   <= '0;
      n_code   <= '0;
      div_code <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (start) begin
            if (out_of_range) begin
              err  <= 1'b1;
              done <= 1'b1;
            end else begin
              err   <= 1'b0;
              f_q   <= target_hz;
              div_q <= '0;
              st    <= S_NORM;
            end
          end
        end
        S_NORM: begin
          if (f_q < VCO_LO_HZ) begin
            f_q   <= {f_q[30:0], 1'b0};
            div_q <= div_q + 8'(DIV_STEP);
          end else begin
            rem_q <= f_q;
            quo_q <= '0;
            st    <= S_QUOT;
          end
        end
        S_QUOT: begin
          if (rem_q >= REF_HZ) begin
            rem_q <= rem_q - REF_HZ;
            quo_q <= quo_q + 1'b1;
          end else begin
            n_q    <= NW'(1);
            m_q    <= quo_q;
            r_q    <= rem_q;
            best_e <= '1;
            best_m <= '0;
            best_n <= '0;
            st     <= S_SRCH;
          end
        end
        S_SRCH: begin
          if (take) begin
            best_e <= cand_e;
            best_m <= m_q;
            best_n <= n_q;
          end
          n_q <= n_q + 1'b1;
          m_q <= m_q + quo_q + MW'(wrap);
          r_q <= wrap ? r_sum - REF_HZ : r_sum;
          if (n_q == N_HI_W) st <= S_FIN;
        end
        S_FIN: begin
          m_code   <= 8'(sel_m - MW'(2));
          n_code   <= 8'(best_n - NW'(2));
          div_code <= div_q | ((best_m > M_HI_W) ? 8'h00 : 8'h04);
          done     <= 1'b1;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  reject_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && out_of_range) |=> (done && err && !busy));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  div_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (div_code[3:0] == 4'h4 || div_code[3:0] == 4'h0));

  // R7
  ext_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err && !div_code[2]) |-> (m_code >= EXT_MIN_CODE));

  // R6
  best_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SRCH && $past(st) == S_SRCH) |-> (best_e <= $past(best_e)));

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SRCH && start) |=> (st == S_SRCH || st == S_FIN));

endmodule

// File: tb/sim_dclk_pll_search.sv
`timescale 1ns/1ps
module sim_dclk_pll_search;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] target_hz = '0;
  logic busy, done, err;
  logic [7:0] m_code, n_code, div_code;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int ext_seen = 0;

  always #2 clk = ~clk;

  dclk_pll_search u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .target_hz(target_hz),
    .busy(busy), .done(done), .err(err),
    .m_code(m_code), .n_code(n_code), .div_code(div_code)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp<=150000 cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] t, output logic e,
                       output logic [7:0] mc, output logic [7:0] nc, output logic [7:0] dc);
    longint f = t;
    longint be = 64'hFFFF_FFFF;
    longint bm = 0;
    longint bn = 0;
    int d = 0;
    mc = 0; nc = 0; dc = 0;
    if (t > 220000000 || t < 3125000) begin
      e = 1'b1;
      return;
    end
    e = 1'b0;
    while (f < 100000000) begin
      f = f * 2;
      d += 16;
    end
    for (int n = 3; n <= 257; n++) begin
      longint m = (longint'(n) * f) / 14318180;
      longint sc;
      if (m >= 3 && m <= 257) sc = longint'(n) * f - 14318180 * m;
      else if (m > 257 && m <= 1028) sc = longint'(n) * f - 14318180 * (m & ~64'd3);
      else continue;
      if (sc < be) begin
        be = sc; bm = m; bn = n;
      end
    end
    if (bm > 257) begin
      mc = 8'((bm >> 2) - 2);
      dc = 8'(d);
    end else begin
      mc = 8'(bm - 2);
      dc = 8'(d | 4);
    end
    nc = 8'(bn - 2);
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (done) begin
        ok = 1;
        return;
      end
    end
  endtask

  task automatic pulse(input logic [31:0] t);
    @(negedge clk);
    start = 1'b1;
    target_hz = t;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Full job: check results against the model; R2/R3/R4/R5/R7/R8
  task automatic run_job(input logic [31:0] t, input string tag);
    logic e; logic [7:0] mc, nc, dc;
    bit ok;
    model(t, e, mc, nc, dc);
    @(negedge clk);
    start = 1'b1;
    target_hz = t;
    wait_done(ok);
    start = 1'b0;
    chk({tag, " done seen"}, 32'(ok), 32'd1);
    chk({tag, " err"}, 32'(err), 32'(e));
    if (!e) begin
      chk({tag, " m_code"}, 32'(m_code), 32'(mc));
      chk({tag, " n_code"}, 32'(n_code), 32'(nc));
      chk({tag, " div_code"}, 32'(div_code), 32'(dc));
      if (!dc[2]) ext_seen++;
    end
    @(negedge clk);
    chk({tag, " R8 done one cycle"}, 32'(done), 32'd0);
  endtask

  task automatic t_reset;
    chk("R10 busy", 32'(busy), 32'd0);
    chk("R10 done", 32'(done), 32'd0);
    chk("R10 err", 32'(err), 32'd0);
    chk("R10 m_code", 32'(m_code), 32'd0);
    chk("R10 n_code", 32'(n_code), 32'd0);
    chk("R10 div_code", 32'(div_code), 32'd0);
  endtask

  task automatic t_reject(input logic [31:0] t);
    logic [7:0] pm, pn, pd;
    pm = m_code; pn = n_code; pd = div_code;
    pulse(t);
    chk("R1 done", 32'(done), 32'd1);
    chk("R1 err", 32'(err), 32'd1);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 m held", 32'(m_code), 32'(pm));
    chk("R1 n held", 32'(n_code), 32'(pn));
    chk("R1 div held", 32'(div_code), 32'(pd));
    repeat (3) @(negedge clk);
    chk("R8 err held", 32'(err), 32'd1);
    chk("R8 done low", 32'(done), 32'd0);
  endtask

  task automatic t_limits;
    run_job(32'd3125000, "R2 low limit");
    chk("R3 five doublings", 32'(div_code[7:4]), 32'd5);
    run_job(32'd220000000, "R2 high limit");
    chk("R3 no doubling", 32'(div_code[7:4]), 32'd0);
  endtask

  task automatic t_band_edge;
    run_job(32'd100000000, "R3 at band");
    chk("R3 at band count", 32'(div_code[7:4]), 32'd0);
    run_job(32'd99999999, "R3 below band");
    chk("R3 below band count", 32'(div_code[7:4]), 32'd1);
  endtask

  task automatic t_common;
    run_job(32'd25175000, "R4 25.175M");
    run_job(32'd40000000, "R4 40M");
    run_job(32'd65000000, "R4 65M");
    run_job(32'd108000000, "R4 108M");
  endtask

  task automatic t_tie;
    run_job(32'd14318180, "R6 ref multiple");
    chk("R6 lowest N", 32'(n_code), 32'd1);
    chk("R6 M for N=3", 32'(m_code), 32'd22);
    chk("R7 div", 32'(div_code), 32'h34);
  endtask

  task automatic t_sweep;
    for (int k = 0; k < 48; k++) begin
      logic [31:0] t;
      t = 32'(3125000 + k * 4518731);
      if (t > 220000000) t = 220000000;
      run_job(t, "R4 R5 sweep");
    end
    for (int k = 0; k < 24; k++) begin
      run_job(32'(150000000 + k * 2711113), "R5 upper band");
    end
  endtask

  task automatic t_busy_ignore;
    logic e; logic [7:0] mc, nc, dc;
    bit ok;
    model(32'd65000000, e, mc, nc, dc);
    pulse(32'd65000000);
    repeat (5) @(negedge clk);
    chk("R9 busy", 32'(busy), 32'd1);
    start = 1'b1;
    target_hz = 32'd1000;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    chk("R9 done", 32'(ok), 32'd1);
    chk("R9 err", 32'(err), 32'd0);
    chk("R9 m_code", 32'(m_code), 32'(mc));
    chk("R9 n_code", 32'(n_code), 32'(nc));
    chk("R9 div_code", 32'(div_code), 32'(dc));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reject(32'd220000001);
    t_reject(32'd3124999);
    t_reject(32'd0);
    t_limits;
    t_band_edge;
    t_common;
    t_tie;
    t_busy_ignore;
    t_reject(32'hFFFF_FFFF);
    t_sweep;
    $display("extended M results seen: %0d", ext_seen);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule